// File: doc/BRIEF.md
# Register File Bit-Flip Monitor

This block watches a small register file for upsets by repeatedly comparing a range of test registers against one golden register. After reset it zeroes the whole file. It then writes a fixed pattern into the golden register and starts an endless ascending scan over the test registers. On each visit the register under test is rewritten from the constant pattern, never from the golden register. It is then XOR-ed with the golden register. The difference goes to an output port and is held for a programmable number of dwell cycles, so that a slow observer can read it.

The golden register is written once during setup and never again. A flip in it therefore shows on every later visit, while a flip in a test register lasts for one visit only. The block keeps a sticky mismatch flag for each test register. It reports whether the last full pass mismatched on every register, which points at the golden register, and whether any mismatch has cleared on the following pass. A test port XORs a mask into any register on a chosen cycle, so a bench can create both kinds of upset.

The controller is a five-state machine. CLEAR zeroes the file and always moves to LOADREF. LOADREF writes the pattern into the golden register and always moves to RELOAD. RELOAD writes the pattern into the current test register and always moves to XOR. XOR writes the difference back into the test register, hands it to the output stage and always moves to DWELL. DWELL counts the dwell cycles. When the count expires it returns to RELOAD and advances the index, wrapping from the last test register to the first. No state ever leads back to CLEAR or LOADREF.

Top module: `rfm_monitor`

## Requirements
- R1: While reset is held, `diff_out` is zero, `upd_stb` is low, `shown_idx` is 16 and all flags are clear. After reset is released, the first strobe comes on the 4th rising edge, with index 16 and a zero difference, because every register was cleared and the golden register 25 was loaded with `PATTERN`.
- R2: Strobed indices run 16, 17, …, 24 in ascending order, then wrap to 16 and repeat without end. No index outside 16..24 is ever shown.
- R3: Each update raises `upd_stb` for exactly one cycle. Consecutive strobes are exactly `DWELL`+2 cycles apart. `diff_out` and `shown_idx` do not change between strobes.
- R4: `diff_out` equals the test register, freshly reloaded from `PATTERN`, XOR the golden register. With no upset it is all zeros.
- R5: A mask injected into a test register on the clock edge that ends that register's RELOAD cycle is shown as the difference for that visit only. The next visit of the same register shows zero. Single-bit and non-adjacent multi-bit masks are both reported.
- R6: A mask injected into a test register at a time outside its reload-to-compare window has no effect on the output, because the register is rewritten before it is next compared.
- R7: A mask injected into golden register 25 appears as the difference on every later visit, since no operation after setup writes that register.
- R8: `err_flags` bit k belongs to register 16+k. The bit sets on the strobe that shows a non-zero difference for that register and stays set until reset.
- R9: `persist_ref` is updated on the strobe of register 24. It is 1 exactly when all nine differences of the pass that ends there were non-zero.
- R10: `transient_seen` sets, and stays set until reset, when a register shows a non-zero difference in one pass and zero on its next visit.
- R11: With `inj_en` high on a clock edge, `inj_mask` is XOR-ed into register `inj_sel` on that edge. If the controller writes the same register on that edge, the mask lands on top of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_en | input | 1 | Test port: apply the upset mask on this edge |
| inj_sel | input | AW (5) | Test port: register to upset |
| inj_mask | input | DW (8) | Test port: bits to flip |
| diff_out | output | DW (8) | Held XOR difference of the last compared register |
| shown_idx | output | AW (5) | Index of the register whose difference is shown |
| upd_stb | output | 1 | One-cycle pulse when the outputs update |
| err_flags | output | NT (9) | Sticky per-test-register mismatch flags |
| persist_ref | output | 1 | Last full pass mismatched on every register |
| transient_seen | output | 1 | Sticky: some mismatch cleared on the next visit |

## Verification
The upset port and the controller's own reload write can hit the same test register on the same clock edge. The bench provokes this by counting `DWELL` cycles after the strobe for register 17 and then pulsing the upset into register 18, which places the pulse exactly in register 18's RELOAD cycle. The result is judged correct if the next strobe shows register 18 with the mask as its difference, and register 18's following visit shows zero and sets the transient flag. A lost mask, or a mask that survives into the next pass, points to the wrong write priority.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

    typedef enum logic [2:0] {
        ST_CLEAR   = 3'd0,
        ST_LOADREF = 3'd1,
        ST_RELOAD  = 3'd2,
        ST_XOR     = 3'd3,
        ST_DWELL   = 3'd4
    } rfm_state_e;

endpackage

// File: rtl/rfm_regfile.sv
module rfm_regfile #(
    parameter int DW    = 8,
    parameter int NREGS = 32,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          inj_en,
    input  logic [AW-1:0] inj_addr,
    input  logic [DW-1:0] inj_mask,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);

    logic [DW-1:0] mem [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        logic [DW-1:0] q;
        logic [DW-1:0] base;
        logic [DW-1:0] flip;

        // the controller write is taken first; an upset lands on top of it
        assign base = (we && waddr == AW'(i)) ? wdata : q;
        assign flip = (inj_en && inj_addr == AW'(i)) ? inj_mask : '0;

        always_ff @(posedge clk) begin
            if (clr) q <= '0;
            else     q <= base ^ flip;
        end

        assign mem[i] = q;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/rfm_sequencer.sv
module rfm_sequencer
    import rfm_pkg::*;
#(
    parameter int              DW      = 8,
    parameter int              AW      = 5,
    parameter int              FIRST   = 16,
    parameter int              LAST    = 24,
    parameter int              REF     = 25,
    parameter int              DWELL   = 4,
    parameter logic [DW-1:0]   PATTERN = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] rd_test,
    input  logic [DW-1:0] rd_ref,
    output logic          clr,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata,
    output logic [AW-1:0] idx,
    output logic          fire,
    output logic [DW-1:0] diff
);

    localparam int            CW      = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(DWELL - 1);
    localparam logic [AW-1:0] IDX_LO  = AW'(FIRST);
    localparam logic [AW-1:0] IDX_HI  = AW'(LAST);
    localparam logic [AW-1:0] IDX_REF = AW'(REF);

    rfm_state_e    state, state_nx;
    logic [AW-1:0] idx_nx;
    logic [CW-1:0] cnt, cnt_nx;

    assign diff = rd_test ^ rd_ref;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CLEAR;
            idx   <= IDX_LO;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
            cnt   <= cnt_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        cnt_nx   = cnt;
        unique case (state)
            ST_CLEAR:   state_nx = ST_LOADREF;
            ST_LOADREF: state_nx = ST_RELOAD;
            ST_RELOAD:  state_nx = ST_XOR;
            ST_XOR: begin
                state_nx = ST_DWELL;
                cnt_nx   = '0;
            end
            ST_DWELL: begin
                if (cnt == CNT_END) begin
                    state_nx = ST_RELOAD;
                    idx_nx   = (idx == IDX_HI) ? IDX_LO : idx + 1'b1;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default:    state_nx = ST_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        clr   = 1'b0;
        we    = 1'b0;
        waddr = idx;
        wdata = PATTERN;
        fire  = 1'b0;
        unique case (state)
            ST_CLEAR:   clr = 1'b1;
            ST_LOADREF: begin
                we    = 1'b1;
                waddr = IDX_REF;
            end
            ST_RELOAD:  we = 1'b1;
            ST_XOR: begin
                we    = 1'b1;
                wdata = diff;
                fire  = 1'b1;
            end
            ST_DWELL:   ;
            default:    ;
        endcase
    end

endmodule

// File: rtl/rfm_classifier.sv
module rfm_classifier #(
    parameter int DW    = 8,
    parameter int AW    = 5,
    parameter int FIRST = 16,
    parameter int LAST  = 24,
    parameter int NT    = LAST - FIRST + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] diff,
    output logic [DW-1:0] diff_out,
    output logic [AW-1:0] shown_idx,
    output logic          upd_stb,
    output logic [NT-1:0] err_flags,
    output logic          persist_ref,
    output logic          transient_seen
);

    localparam logic [AW-1:0] IDX_LO = AW'(FIRST);
    localparam logic [AW-1:0] IDX_HI = AW'(LAST);

    logic [NT-1:0] hit;
    logic [NT-1:0] prev_nz;
    logic          nz;
    logic          pass_all;
    logic          pass_all_nx;
    logic          clears;

    for (genvar k = 0; k < NT; k++) begin : g_hit
        assign hit[k] = fire && (idx == AW'(FIRST + k));
    end

    assign nz          = |diff;
    assign pass_all_nx = (idx == IDX_LO) ? nz : (pass_all & nz);
    assign clears      = |(hit & prev_nz) && !nz;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            diff_out       <= '0;
            shown_idx      <= IDX_LO;
            upd_stb        <= 1'b0;
            err_flags      <= '0;
            prev_nz        <= '0;
            pass_all       <= 1'b0;
            persist_ref    <= 1'b0;
            transient_seen <= 1'b0;
        end else begin
            upd_stb <= fire;
            if (fire) begin
                diff_out  <= diff;
                shown_idx <= idx;
                pass_all  <= pass_all_nx;
                if (idx == IDX_HI) persist_ref <= pass_all_nx;
                if (clears) transient_seen <= 1'b1;
                for (int k = 0; k < NT; k++) begin
                    if (hit[k]) begin
                        prev_nz[k] <= nz;
                        if (nz) err_flags[k] <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rfm_monitor.sv
module rfm_monitor #(
    parameter int            DW      = 8,
    parameter int            NREGS   = 32,
    parameter int            FIRST   = 16,
    parameter int            LAST    = 24,
    parameter int            REF     = 25,
    parameter int            DWELL   = 4,
    parameter logic [DW-1:0] PATTERN = '0,
    localparam int           AW      = $clog2(NREGS),
    localparam int           NT      = LAST - FIRST + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inj_en,
    input  logic [AW-1:0] inj_sel,
    input  logic [DW-1:0] inj_mask,
    output logic [DW-1:0] diff_out,
    output logic [AW-1:0] shown_idx,
    output logic          upd_stb,
    output logic [NT-1:0] err_flags,
    output logic          persist_ref,
    output logic          transient_seen
);

    logic          clr, we, fire;
    logic [AW-1:0] waddr, idx;
    logic [DW-1:0] wdata, rd_test, rd_ref, diff;

    rfm_regfile #(.DW(DW), .NREGS(NREGS), .AW(AW)) u_rf (
        .clk      (clk),
        .clr      (clr),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wdata),
        .inj_en   (inj_en),
        .inj_addr (inj_sel),
        .inj_mask (inj_mask),
        .raddr_a  (idx),
        .rdata_a  (rd_test),
        .raddr_b  (AW'(REF)),
        .rdata_b  (rd_ref)
    );

    rfm_sequencer #(
        .DW(DW), .AW(AW), .FIRST(FIRST), .LAST(LAST), .REF(REF),
        .DWELL(DWELL), .PATTERN(PATTERN)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_test (rd_test),
        .rd_ref  (rd_ref),
        .clr     (clr),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .idx     (idx),
        .fire    (fire),
        .diff    (diff)
    );

    rfm_classifier #(
        .DW(DW), .AW(AW), .FIRST(FIRST), .LAST(LAST), .NT(NT)
    ) u_cls (
        .clk            (clk),
        .rst_n          (rst_n),
        .fire           (fire),
        .idx            (idx),
        .diff           (diff),
        .diff_out       (diff_out),
        .shown_idx      (shown_idx),
        .upd_stb        (upd_stb),
        .err_flags      (err_flags),
        .persist_ref    (persist_ref),
        .transient_seen (transient_seen)
    );

endmodule

// File: rtl/rfm_checker.sv
module rfm_checker #(
    parameter int DW    = 8,
    parameter int AW    = 5,
    parameter int FIRST = 16,
    parameter int LAST  = 24,
    parameter int NT    = LAST - FIRST + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          upd_stb,
    input logic [AW-1:0] shown_idx,
    input logic [DW-1:0] diff_out,
    input logic [NT-1:0] err_flags,
    input logic          persist_ref
);

    logic          have_prev;
    logic [AW-1:0] prev_idx;
    logic [AW-1:0] want_idx;
    logic [NT-1:0] sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev_idx  <= AW'(FIRST);
        end else if (upd_stb) begin
            have_prev <= 1'b1;
            prev_idx  <= shown_idx;
        end
    end

    assign want_idx = (prev_idx == AW'(LAST)) ? AW'(FIRST) : prev_idx + 1'b1;

    always_comb begin
        sel = '0;
        for (int k = 0; k < NT; k++)
            if (shown_idx == AW'(FIRST + k)) sel[k] = 1'b1;
    end

    // R3: strobe is a single-cycle pulse
    p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> !upd_stb);

    // R3: shown values hold between strobes
    p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb |-> ($stable(diff_out) && $stable(shown_idx)));

    // R2: shown index stays inside the test range
    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shown_idx >= AW'(FIRST)) && (shown_idx <= AW'(LAST)));

    // R2: ascending order with wrap
    p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && have_prev) |-> (shown_idx == want_idx));

    // R8: sticky flags never clear while out of reset
    p_flags_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_flags & $past(err_flags)) == $past(err_flags)));

    // R8: a non-zero difference has its flag set
    p_flag_on_diff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && diff_out != '0) |-> ((err_flags & sel) != '0));

    // R9: a clean last register rules out a persistent verdict
    p_persist_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && shown_idx == AW'(LAST) && diff_out == '0) |-> !persist_ref);

endmodule

bind rfm_monitor rfm_checker #(
    .DW(DW), .AW(AW), .FIRST(FIRST), .LAST(LAST), .NT(NT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_stb     (upd_stb),
    .shown_idx   (shown_idx),
    .diff_out    (diff_out),
    .err_flags   (err_flags),
    .persist_ref (persist_ref)
);

// File: tb/sim_rfm_monitor.sv
`timescale 1ns/1ps
module sim_rfm_monitor;

    localparam int         DWB   = 8;
    localparam int         NR    = 32;
    localparam int         AWB   = 5;
    localparam int         NTB   = 9;
    localparam int         DWL   = 3;
    localparam logic [7:0] PAT   = 8'hC3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             inj_en = 1'b0;
    logic [AWB-1:0]   inj_sel = '0;
    logic [DWB-1:0]   inj_mask = '0;
    logic [DWB-1:0]   diff_out;
    logic [AWB-1:0]   shown_idx;
    logic             upd_stb;
    logic [NTB-1:0]   err_flags;
    logic             persist_ref;
    logic             transient_seen;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rfm_monitor #(
        .DW(DWB), .NREGS(NR), .FIRST(16), .LAST(24), .REF(25),
        .DWELL(DWL), .PATTERN(PAT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .inj_en(inj_en), .inj_sel(inj_sel),
        .inj_mask(inj_mask), .diff_out(diff_out), .shown_idx(shown_idx),
        .upd_stb(upd_stb), .err_flags(err_flags), .persist_ref(persist_ref),
        .transient_seen(transient_seen)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic next_strobe(output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!upd_stb && gap < 2000);
    endtask

    task automatic advance_to(input int want);
        int g;
        do next_strobe(g); while (int'(shown_idx) != want);
    endtask

    task automatic upset(input int sel, input logic [7:0] mask);
        inj_en   = 1'b1;
        inj_sel  = AWB'(sel);
        inj_mask = mask;
        @(negedge clk);
        inj_en   = 1'b0;
        inj_mask = '0;
    endtask

    // R1: reset state and first result
    task automatic t_reset;
        int g;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(diff_out == 0 && !upd_stb, "R1", "outputs in reset",
            int'(diff_out), 0);
        chk(err_flags == 0 && !persist_ref && !transient_seen, "R1",
            "flags in reset", int'(err_flags), 0);
        chk(shown_idx == 5'd16, "R1", "index in reset", int'(shown_idx), 16);
        rst_n = 1'b1;
        next_strobe(g);
        chk(g == 4, "R1", "first strobe edge", g, 4);
        chk(shown_idx == 5'd16, "R1", "first index", int'(shown_idx), 16);
        chk(diff_out == 0, "R1", "first difference", int'(diff_out), 0);
    endtask

    // R2 R3 R4: one clean pass with wrap
    task automatic t_clean_pass;
        int g;
        int exp_idx;
        bit ord_ok = 1'b1, gap_ok = 1'b1, zero_ok = 1'b1;
        int bad_idx = 0, bad_gap = 0, bad_diff = 0;
        for (int k = 1; k <= 9; k++) begin
            next_strobe(g);
            exp_idx = (k == 9) ? 16 : 16 + k;
            if (int'(shown_idx) != exp_idx) begin ord_ok = 1'b0; bad_idx = int'(shown_idx); end
            if (g != DWL + 2) begin gap_ok = 1'b0; bad_gap = g; end
            if (diff_out != 0) begin zero_ok = 1'b0; bad_diff = int'(diff_out); end
            @(negedge clk);
            chk(!upd_stb, "R3", "strobe width", int'(upd_stb), 0);
            g = 1;
            while (!upd_stb && g < DWL + 1) begin @(negedge clk); g++; end
            chk(!upd_stb, "R3", "no early strobe", int'(upd_stb), 0);
            // re-sync: remaining wait handled by a shortened next_strobe
            do begin @(negedge clk); g++; end while (!upd_stb && g < 2000);
            if (k < 9) begin
                exp_idx = 17 + k;
                if (k == 8) exp_idx = 16;
            end
            // count the strobe just found as the next visit
            k++;
            if (k <= 9) begin
                exp_idx = (k == 9) ? 16 : 16 + k;
                if (int'(shown_idx) != exp_idx) begin ord_ok = 1'b0; bad_idx = int'(shown_idx); end
                if (g != DWL + 2) begin gap_ok = 1'b0; bad_gap = g; end
                if (diff_out != 0) begin zero_ok = 1'b0; bad_diff = int'(diff_out); end
            end
        end
        chk(ord_ok, "R2", "ascending order and wrap", bad_idx, 16);
        chk(gap_ok, "R3", "strobe spacing", bad_gap, DWL + 2);
        chk(zero_ok, "R4", "clean difference", bad_diff, 0);
        chk(err_flags == 0 && !persist_ref && !transient_seen, "R8",
            "flags after clean pass", int'(err_flags), 0);
    endtask

    // R6: upset outside the window is overwritten
    task automatic t_overwrite;
        advance_to(16);
        upset(20, 8'hFF);
        advance_to(20);
        chk(diff_out == 0, "R6", "late upset hidden", int'(diff_out), 0);
        chk(err_flags == 0, "R6", "no flag from hidden upset", int'(err_flags), 0);
    endtask

    // R5 R10 R11: upset collides with reload of register 18
    task automatic t_transient;
        int g;
        advance_to(17);
        repeat (DWL) @(negedge clk);
        upset(18, 8'h81);
        next_strobe(g);
        chk(shown_idx == 5'd18, "R11", "collision visit index", int'(shown_idx), 18);
        chk(diff_out == 8'h81, "R5", "non-adjacent flips shown", int'(diff_out), 'h81);
        chk(err_flags == 9'h004, "R8", "flag of register 18", int'(err_flags), 'h004);
        chk(!transient_seen, "R10", "not yet transient", int'(transient_seen), 0);
        advance_to(24);
        chk(!persist_ref, "R9", "single mismatch not persistent", int'(persist_ref), 0);
        advance_to(18);
        chk(diff_out == 0, "R5", "next visit clean", int'(diff_out), 0);
        chk(transient_seen, "R10", "transient classified", int'(transient_seen), 1);
        chk(err_flags == 9'h004, "R8", "flag stays set", int'(err_flags), 'h004);
    endtask

    // R7 R9: upset in golden register persists
    task automatic t_persistent;
        bit all_ok = 1'b1;
        int bad = 0;
        upset(25, 8'h26);
        advance_to(24);
        chk(diff_out == 8'h26, "R7", "golden upset visible", int'(diff_out), 'h26);
        chk(!persist_ref, "R9", "partial pass not persistent", int'(persist_ref), 0);
        for (int k = 16; k <= 24; k++) begin
            advance_to(k);
            if (diff_out != 8'h26) begin all_ok = 1'b0; bad = int'(diff_out); end
        end
        chk(all_ok, "R7", "every visit mismatches", bad, 'h26);
        chk(persist_ref, "R9", "full pass persistent", int'(persist_ref), 1);
        chk(err_flags == 9'h1FF, "R8", "all flags set", int'(err_flags), 'h1FF);
    endtask

    initial begin
        t_reset;
        t_clean_pass;
        t_overwrite;
        t_transient;
        t_persistent;
        t_reset;
        chk(err_flags == 0 && !persist_ref && !transient_seen, "R1",
            "reset recovers", int'(err_flags), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule